// File: doc/BRIEF.md
# Trigger Window Hit Selector

This block sits behind a time-ordered FIFO of timestamped detector hits. Each hit carries a channel number, a coarse timestamp counted in coarse clock periods and a fine time. When a trigger strobe arrives, the block takes the coarse time it carries as the reference point. It then walks the FIFO head and emits, as one event, every hit whose coarse timestamp lies inside a programmable window around that reference. The event stream ends with a beat that carries a last flag. That beat also carries a truncation flag when a per-event hit cap cut hits away.

The window is built from two signed offsets, one for the start and one for the end, each with its own enable. Hits older than the start are consumed and thrown away. Hits newer than the end are left at the FIFO head for later triggers. When the end lies in the future, the block holds the event open until the running coarse time has moved past it. Both input and output are valid/ready streams. Trigger, configuration, the busy indicator and a sticky loss flag fed by the FIFO's discard strobe are plain pins.

Back-pressure rules: a beat on the output is transferred when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the beat and all of its flags stay unchanged. The hit source must keep `hit_valid` and the head hit stable until `hit_ready` takes it. `hit_ready` never depends on anything but the block's state, the head hit, the running time and `out_ready`.

Top module: `trig_window_selector`

## Requirements
- R1: With both enables set, the window runs from trigger time plus start offset to trigger time plus end offset, both ends inclusive. The offsets are 15-bit two's-complement counts of coarse periods, and negative values point into the past. In-window hits leave in FIFO order with channel, coarse and fine time unchanged.
- R2: With the start enable low, every hit ahead of the first hit newer than the window end is part of the event.
- R3: With the end enable low, the window end equals the trigger time and the end offset has no effect.
- R4: Hits older than an enabled window start are popped and discarded. Hits newer than the window end are not popped and stay in the FIFO.
- R5: When no hit is waiting, the event closes only once the running coarse time is strictly later than the window end.
- R6: The 5-bit cap field sets a limit. With bit 4 set, the number of hits is unlimited. With bit 4 clear, at most the value in bits 3..0 is emitted. Further in-window hits are popped and discarded, and `out_trunc` is 1 on the last beat.
- R7: The final beat of an event has `out_last` = 1. An event with no emitted hit is a single beat with `out_last` = 1, `out_empty` = 1 and zero data.
- R8: Timestamps are 28 bits wide and wrap. Every ordering test is a modular signed difference, so windows that straddle the wrap behave like any other window.
- R9: An output beat that is stalled by `out_ready` = 0 keeps its data and flags until it is taken.
- R10: `busy` is high from the trigger until the last beat is taken. A trigger that arrives while `busy` is high is ignored and adds no event.
- R11: `loss_flag` is set by `fifo_drop` and stays set until `loss_clear`. When both arrive in the same cycle, the flag stays set.
- R12: After reset, `out_valid`, `hit_ready`, `busy` and `loss_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Head hit present |
| hit_ready | output | 1 | Head hit consumed this cycle |
| hit_chan | input | CH_W | Channel of head hit |
| hit_coarse | input | TS_W | Coarse timestamp of head hit |
| hit_fine | input | FINE_W | Fine time of head hit |
| now_time | input | TS_W | Running coarse time |
| trig_valid | input | 1 | Trigger strobe |
| trig_time | input | TS_W | Coarse time of the trigger cycle |
| cfg_start_off | input | OFF_W | Signed window start offset |
| cfg_start_en | input | 1 | Start offset enable |
| cfg_end_off | input | OFF_W | Signed window end offset |
| cfg_end_en | input | 1 | End offset enable |
| cfg_max_hits | input | LIM_W | Hit cap, top bit means unlimited |
| out_valid | output | 1 | Event beat present |
| out_ready | input | 1 | Downstream accepts beat |
| out_chan | output | CH_W | Channel of emitted hit |
| out_coarse | output | TS_W | Coarse time of emitted hit |
| out_fine | output | FINE_W | Fine time of emitted hit |
| out_last | output | 1 | Final beat of event |
| out_trunc | output | 1 | Event was cut by the cap (last beat only) |
| out_empty | output | 1 | Marker beat without hit data |
| busy | output | 1 | Event in progress |
| fifo_drop | input | 1 | Hit FIFO discarded data this cycle |
| loss_clear | input | 1 | Clears the loss flag |
| loss_flag | output | 1 | Sticky loss indicator |

## Verification
The first window straddles the timestamp wrap and ends well in the future. It separates a correct modular comparison from a plain unsigned one, and a block that waits for time to pass from one that closes as soon as the FIFO runs dry. Windows entirely in the past, with hits just outside each boundary, show whether the ends are inclusive and whether old and new hits are popped or kept. Runs with each enable low show that the disabled bound is replaced as specified. Capped runs, with the unlimited bit set and clear, together with an empty window, exercise truncation and the marker beat. Random back-pressure on the output and a trigger injected mid-event check stall stability and that extra triggers are dropped.

// File: rtl/twhs_pkg.sv
package twhs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_CLOSE = 2'd2
  } sel_state_t;

  typedef enum logic [1:0] {
    HC_NONE = 2'd0,
    HC_OLD  = 2'd1,
    HC_IN   = 2'd2,
    HC_NEW  = 2'd3
  } hit_cls_t;
endpackage

// File: rtl/twhs_window.sv
module twhs_window #(
  parameter int TS_W  = 28,
  parameter int OFF_W = 15,
  parameter int LIM_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TS_W-1:0]    trig_time,
  input  logic [OFF_W-1:0]   start_off,
  input  logic               start_en,
  input  logic [OFF_W-1:0]   end_off,
  input  logic               end_en,
  input  logic [LIM_W-1:0]   max_hits,
  output logic [TS_W-1:0]    win_start,
  output logic               win_start_en,
  output logic [TS_W-1:0]    win_end,
  output logic               lim_unl,
  output logic [LIM_W-2:0]   lim_val
);
  localparam int EXT_W = TS_W - OFF_W;

  logic [TS_W-1:0] start_ext, end_ext;
  assign start_ext = {{EXT_W{start_off[OFF_W-1]}}, start_off};
  assign end_ext   = end_en ? {{EXT_W{end_off[OFF_W-1]}}, end_off} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_start    <= '0;
      win_start_en <= 1'b0;
      win_end      <= '0;
      lim_unl      <= 1'b0;
      lim_val      <= '0;
    end else if (load) begin
      win_start    <= trig_time + start_ext;
      win_start_en <= start_en;
      win_end      <= trig_time + end_ext;
      lim_unl      <= max_hits[LIM_W-1];
      lim_val      <= max_hits[LIM_W-2:0];
    end
  end

  // R3: with end disabled, the latched end is the trigger time itself
  assert_end_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !end_en) |=> (win_end == $past(trig_time)));
endmodule

// File: rtl/twhs_classify.sv
module twhs_classify import twhs_pkg::*; #(
  parameter int TS_W = 28
) (
  input  logic            hit_valid,
  input  logic [TS_W-1:0] hit_time,
  input  logic [TS_W-1:0] now_time,
  input  logic [TS_W-1:0] win_start,
  input  logic            win_start_en,
  input  logic [TS_W-1:0] win_end,
  output hit_cls_t        cls,
  output logic            past_end
);
  logic [TS_W-1:0] d_end, d_start, d_now;

  assign d_end   = hit_time - win_end;
  assign d_start = hit_time - win_start;
  assign d_now   = now_time - win_end;

  // a positive modular difference means strictly later
  assign past_end = !d_now[TS_W-1] && (d_now != '0);

  always_comb begin
    if (!hit_valid)                                   cls = HC_NONE;
    else if (!d_end[TS_W-1] && (d_end != '0))         cls = HC_NEW;
    else if (win_start_en && d_start[TS_W-1])         cls = HC_OLD;
    else                                              cls = HC_IN;
  end
endmodule

// File: rtl/twhs_loss.sv
module twhs_loss (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (drop)  flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end

  assert_loss_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flag);
  assert_loss_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag);
endmodule

// File: rtl/trig_window_selector.sv
module trig_window_selector import twhs_pkg::*; #(
  parameter int CH_W   = 6,
  parameter int TS_W   = 28,
  parameter int FINE_W = 10,
  parameter int OFF_W  = 15,
  parameter int LIM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [CH_W-1:0]   hit_chan,
  input  logic [TS_W-1:0]   hit_coarse,
  input  logic [FINE_W-1:0] hit_fine,
  input  logic [TS_W-1:0]   now_time,
  input  logic              trig_valid,
  input  logic [TS_W-1:0]   trig_time,
  input  logic [OFF_W-1:0]  cfg_start_off,
  input  logic              cfg_start_en,
  input  logic [OFF_W-1:0]  cfg_end_off,
  input  logic              cfg_end_en,
  input  logic [LIM_W-1:0]  cfg_max_hits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [TS_W-1:0]   out_coarse,
  output logic [FINE_W-1:0] out_fine,
  output logic              out_last,
  output logic              out_trunc,
  output logic              out_empty,
  output logic              busy,
  input  logic              fifo_drop,
  input  logic              loss_clear,
  output logic              loss_flag
);
  localparam int CNT_W = LIM_W - 1;

  sel_state_t        st, st_nx;
  hit_cls_t          cls;
  logic              past_end, load;
  logic [TS_W-1:0]   w_start, w_end;
  logic              w_start_en, lim_unl;
  logic [CNT_W-1:0]  lim_val, cnt;
  logic              held_v, trunc_r, take, set_trunc, room;
  logic [CH_W-1:0]   held_chan;
  logic [TS_W-1:0]   held_coarse;
  logic [FINE_W-1:0] held_fine;

  assign load = (st == ST_IDLE) && trig_valid;
  assign busy = (st != ST_IDLE);
  assign room = lim_unl || (cnt < lim_val);

  twhs_window #(.TS_W(TS_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(load), .trig_time(trig_time),
    .start_off(cfg_start_off), .start_en(cfg_start_en),
    .end_off(cfg_end_off), .end_en(cfg_end_en), .max_hits(cfg_max_hits),
    .win_start(w_start), .win_start_en(w_start_en), .win_end(w_end),
    .lim_unl(lim_unl), .lim_val(lim_val)
  );

  twhs_classify #(.TS_W(TS_W)) u_cls (
    .hit_valid(hit_valid && (st == ST_SCAN)), .hit_time(hit_coarse),
    .now_time(now_time), .win_start(w_start), .win_start_en(w_start_en),
    .win_end(w_end), .cls(cls), .past_end(past_end)
  );

  twhs_loss u_loss (
    .clk(clk), .rst_n(rst_n), .drop(fifo_drop), .clear(loss_clear),
    .flag(loss_flag)
  );

  always_comb begin
    st_nx     = st;
    hit_ready = 1'b0;
    take      = 1'b0;
    set_trunc = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_trunc = 1'b0;
    out_empty = 1'b0;
    unique case (st)
      ST_IDLE: if (trig_valid) st_nx = ST_SCAN;
      ST_SCAN: begin
        unique case (cls)
          HC_NONE: if (past_end) st_nx = ST_CLOSE;
          HC_NEW:  st_nx = ST_CLOSE;
          HC_OLD:  hit_ready = 1'b1;
          HC_IN: begin
            if (!room) begin
              hit_ready = 1'b1;
              set_trunc = 1'b1;
            end else if (!held_v) begin
              hit_ready = 1'b1;
              take      = 1'b1;
            end else begin
              out_valid = 1'b1;
              if (out_ready) begin
                hit_ready = 1'b1;
                take      = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      ST_CLOSE: begin
        out_valid = 1'b1;
        out_last  = 1'b1;
        out_trunc = trunc_r;
        out_empty = !held_v;
        if (out_ready) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign out_chan   = held_v ? held_chan   : '0;
  assign out_coarse = held_v ? held_coarse : '0;
  assign out_fine   = held_v ? held_fine   : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      held_v      <= 1'b0;
      held_chan   <= '0;
      held_coarse <= '0;
      held_fine   <= '0;
      cnt         <= '0;
      trunc_r     <= 1'b0;
    end else begin
      st <= st_nx;
      if (load) begin
        cnt     <= '0;
        trunc_r <= 1'b0;
      end
      if (set_trunc) trunc_r <= 1'b1;
      if (take) begin
        held_v      <= 1'b1;
        held_chan   <= hit_chan;
        held_coarse <= hit_coarse;
        held_fine   <= hit_fine;
        if (!lim_unl) cnt <= cnt + 1'b1;
      end
      if ((st == ST_CLOSE) && out_ready) held_v <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) &&
      $stable(out_coarse) && $stable(out_fine) && $stable(out_last) &&
      $stable(out_trunc) && $stable(out_empty)));
  assert_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy);
  assert_idle_nopop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!hit_ready && !out_valid));
  assert_empty_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> out_last);
  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lim_unl) |-> (cnt <= lim_val));
  assert_trunc_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_trunc |-> (out_valid && out_last));
endmodule

// File: tb/sim_trig_window_selector.sv
`timescale 1ns/1ps
module sim_trig_window_selector;
  localparam int CH_W = 6, TS_W = 28, FINE_W = 10, OFF_W = 15, LIM_W = 5;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic              last;
    logic              trunc;
    logic              empty;
    logic [CH_W-1:0]   chan;
    logic [TS_W-1:0]   coarse;
    logic [FINE_W-1:0] fine;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_valid = 0, hit_ready;
  logic [CH_W-1:0] hit_chan = '0;
  logic [TS_W-1:0] hit_coarse = '0, now_time = 28'hFFFFFC0, trig_time = '0;
  logic [FINE_W-1:0] hit_fine = '0;
  logic trig_valid = 0, cfg_start_en = 0, cfg_end_en = 0;
  logic [OFF_W-1:0] cfg_start_off = '0, cfg_end_off = '0;
  logic [LIM_W-1:0] cfg_max_hits = '0;
  logic out_valid, out_ready = 0, out_last, out_trunc, out_empty, busy;
  logic [CH_W-1:0] out_chan;
  logic [TS_W-1:0] out_coarse;
  logic [FINE_W-1:0] out_fine;
  logic fifo_drop = 0, loss_clear = 0, loss_flag;

  always #2.5 clk = ~clk;

  trig_window_selector #(.CH_W(CH_W), .TS_W(TS_W), .FINE_W(FINE_W),
    .OFF_W(OFF_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_chan(hit_chan), .hit_coarse(hit_coarse), .hit_fine(hit_fine),
    .now_time(now_time), .trig_valid(trig_valid), .trig_time(trig_time),
    .cfg_start_off(cfg_start_off), .cfg_start_en(cfg_start_en),
    .cfg_end_off(cfg_end_off), .cfg_end_en(cfg_end_en),
    .cfg_max_hits(cfg_max_hits), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_coarse(out_coarse), .out_fine(out_fine),
    .out_last(out_last), .out_trunc(out_trunc), .out_empty(out_empty),
    .busy(busy), .fifo_drop(fifo_drop), .loss_clear(loss_clear),
    .loss_flag(loss_flag)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit wd_hit = 0;
  logic [CH_W+TS_W+FINE_W-1:0] hq[$];
  beat_t exp_q[$];
  int exp_rem = 0;
  logic [TS_W-1:0] exp_end = '0;
  bit ev_open = 0, trig_req = 0, drop_req = 0, clr_req = 0, always_rdy = 0;
  bit chk_future = 0;
  string tag = "R1";
  bit prev_stall = 0;
  beat_t prev_beat;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [TS_W-1:0] sx(input logic [OFF_W-1:0] v);
    return {{(TS_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  // reference model: builds the expected event from the current FIFO image
  task automatic model(input logic [TS_W-1:0] t);
    logic [TS_W-1:0] ws, we, dd;
    int n = 0, used = 0;
    bit tr = 0, unl;
    int lim;
    beat_t b;
    ws = t + sx(cfg_start_off);
    we = cfg_end_en ? t + sx(cfg_end_off) : t;
    unl = cfg_max_hits[LIM_W-1];
    lim = int'(cfg_max_hits[LIM_W-2:0]);
    exp_end = we;
    exp_q.delete();
    for (int i = 0; i < hq.size(); i++) begin
      logic [TS_W-1:0] tc;
      tc = hq[i][TS_W+FINE_W-1:FINE_W];
      dd = tc - we;
      if (!dd[TS_W-1] && dd != '0) break;
      used = i + 1;
      dd = tc - ws;
      if (cfg_start_en && dd[TS_W-1]) continue;
      if (unl || n < lim) begin
        b = '0;
        {b.chan, b.coarse, b.fine} = hq[i];
        exp_q.push_back(b);
        n++;
      end else tr = 1;
    end
    exp_rem = hq.size() - used;
    if (exp_q.size() == 0) begin
      b = '0; b.empty = 1; b.last = 1; b.trunc = tr;
      exp_q.push_back(b);
    end else begin
      exp_q[exp_q.size()-1].last = 1;
      exp_q[exp_q.size()-1].trunc = tr;
    end
  endtask

  task automatic cycle();
    beat_t got, e;
    logic [TS_W-1:0] dn;
    @(negedge clk);
    now_time   = now_time + 1'b1;
    hit_valid  = hq.size() > 0;
    {hit_chan, hit_coarse, hit_fine} = hq.size() > 0 ? hq[0] : '0;
    out_ready  = always_rdy || ($urandom_range(0, 3) != 0);
    trig_valid = trig_req;
    trig_time  = now_time;
    fifo_drop  = drop_req;
    loss_clear = clr_req;
    if (trig_req && !ev_open) begin
      model(now_time);
      ev_open = 1;
    end
    trig_req = 0; drop_req = 0; clr_req = 0;
    #2;
    got = {out_last, out_trunc, out_empty, out_chan, out_coarse, out_fine};
    if (prev_stall)
      check(out_valid && got == prev_beat, "R9", "stalled beat changed",
            longint'(got), longint'(prev_beat));
    prev_stall = out_valid && !out_ready;
    prev_beat  = got;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, tag, "unexpected beat", longint'(got), 0);
      end else begin
        e = exp_q.pop_front();
        check(got.last == e.last, e.last ? "R7" : tag, "last flag",
              got.last, e.last);
        check(got.trunc == e.trunc, "R6", "trunc flag", got.trunc, e.trunc);
        check(got.empty == e.empty, "R7", "empty flag", got.empty, e.empty);
        if (!e.empty)
          check({got.chan, got.coarse, got.fine} == {e.chan, e.coarse, e.fine},
                tag, "hit data", longint'(got), longint'(e));
        if (got.last) begin
          check(hq.size() == exp_rem, "R4", "hits left in FIFO",
                hq.size(), exp_rem);
          if (chk_future) begin
            dn = now_time - exp_end;
            check(!dn[TS_W-1] && dn != '0, "R5", "closed before end passed",
                  now_time, exp_end);
          end
          ev_open = 0;
        end
      end
    end
    if (hit_valid && hit_ready) void'(hq.pop_front());
    cyc++;
    if (cyc > WD_LIMIT) wd_hit = 1;
  endtask

  task automatic push_hit(input int rel, input int ch);
    logic [TS_W-1:0] tc;
    tc = now_time + 1'b1 + TS_W'(rel);
    hq.push_back({CH_W'(ch), tc, FINE_W'(ch * 37 + rel)});
  endtask

  task automatic set_cfg(input int so, input bit se, input int eo, input bit ee,
                         input int mh);
    cfg_start_off = OFF_W'(so); cfg_start_en = se;
    cfg_end_off   = OFF_W'(eo); cfg_end_en   = ee;
    cfg_max_hits  = LIM_W'(mh);
  endtask

  task automatic run_event();
    int guard = 0;
    trig_req = 1;
    cycle();
    while (ev_open && guard < 2000 && !wd_hit) begin
      cycle();
      guard++;
    end
    check(!ev_open, tag, "event did not finish", ev_open, 0);
  endtask

  initial begin
    repeat (3) cycle();
    check(!out_valid && !hit_ready && !busy && !loss_flag, "R12",
          "reset outputs", {out_valid, hit_ready, busy, loss_flag}, 0);
    @(negedge clk); rst_n = 1;
    cycle();

    // future end straddling the timestamp wrap
    tag = "R8"; chk_future = 1;
    set_cfg(-10, 1, 80, 1, 16);
    push_hit(-20, 1); push_hit(-10, 2); push_hit(-5, 3);
    push_hit(40, 4); push_hit(70, 5); push_hit(80, 6);
    run_event();
    chk_future = 0;

    // window in the past, boundary hits on both sides
    tag = "R1";
    set_cfg(-8, 1, -2, 1, 16);
    push_hit(-12, 7); push_hit(-8, 8); push_hit(-5, 9);
    push_hit(-2, 10); push_hit(-1, 11); push_hit(3, 12);
    run_event();

    // start disabled: all older hits belong to the event
    tag = "R2";
    set_cfg(-3, 0, -1, 1, 16);
    push_hit(-4, 13); push_hit(-1, 14); push_hit(0, 15);
    run_event();

    // end disabled: end offset value must not matter
    tag = "R3";
    set_cfg(-6, 1, 50, 0, 16);
    push_hit(-3, 16); push_hit(0, 17); push_hit(1, 18);
    run_event();

    // cap of 3 with six in-window hits
    tag = "R6";
    set_cfg(-20, 1, 0, 1, 3);
    for (int i = 0; i < 6; i++) push_hit(-15 + i, 20 + i);
    push_hit(5, 30);
    run_event();

    // unlimited bit set with small low bits
    tag = "R6";
    set_cfg(-40, 1, 10, 1, 5'b10010);
    for (int i = 0; i < 4; i++) push_hit(i, 31 + i);
    run_event();

    // empty window gives a marker beat
    tag = "R7";
    set_cfg(-5, 1, -3, 1, 16);
    push_hit(2, 40);
    run_event();

    // trigger while busy is ignored
    tag = "R10"; always_rdy = 1; chk_future = 1;
    set_cfg(-2, 1, 60, 1, 16);
    push_hit(5, 41);
    trig_req = 1;
    cycle();
    repeat (10) cycle();
    check(busy, "R10", "busy during open event", busy, 1);
    set_cfg(-500, 0, 1000, 1, 16);
    trig_req = 1;
    begin
      int guard = 0;
      while (ev_open && guard < 2000 && !wd_hit) begin cycle(); guard++; end
    end
    chk_future = 0;
    begin
      bit quiet = 1;
      for (int i = 0; i < 20; i++) begin
        cycle();
        if (out_valid || busy) quiet = 0;
      end
      check(quiet, "R10", "extra event after ignored trigger", !quiet, 0);
    end
    always_rdy = 0;

    // sticky loss flag
    drop_req = 1; cycle(); cycle();
    check(loss_flag, "R11", "flag after drop", loss_flag, 1);
    repeat (5) cycle();
    check(loss_flag, "R11", "flag sticky", loss_flag, 1);
    clr_req = 1; cycle(); cycle();
    check(!loss_flag, "R11", "flag after clear", loss_flag, 0);
    drop_req = 1; clr_req = 1; cycle(); cycle();
    check(loss_flag, "R11", "drop wins over clear", loss_flag, 1);

    if (wd_hit) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule